// File: doc/BRIEF.md
# Filter Coefficient Store with Staged Host Access

This block holds the coefficients of an audio filter datapath: 62 words of 24 bits each. A controller reaches the store through a byte-wide register port. It loads an index register and a bank of staging bytes, then writes a strobe bit into a control register. The strobe starts one of four transfers:

- write one word from the staging bytes into the store;
- write a whole five-word filter section;
- read one word back into the staging bytes;
- read five words back into the staging bytes.

The controller polls a status register until the transfer has finished.

The filter datapath has its own read port. It presents a word index and receives the stored word one clock later. A five-word section write lands in the store in a single clock cycle, so the datapath never sees a section with only some of its words updated. Each word has a fixed reset value. The arithmetic that uses the words is not part of this block.

Top module: `coef_ram_ctrl`

## Requirements
- R1: After reset, the store holds these values. Indices 4, 9, 14, …, 49 hold 0x400000. Indices 50–54, 56 and 59 hold 0x7FFFFF. Index 55 holds 0x5A9DF7. Indices 60 and 61 hold 0x400000. Every other index holds 0. The control register reads 0x00 and the status register reads 0x00.
- R2: The host register map is as follows. Address 0 is the index register. Addresses 1–15 are the staging bytes. Address 16 is the control register. Address 17 is status, with bit 0 meaning busy. When `hst_rd` is high at a clock edge, `hst_rdata` shows the addressed register after that edge. An unmapped address reads 0, and `hst_rdata` is 0 after any edge without a read.
- R3: Staging bytes 3k+1, 3k+2 and 3k+3 form word k (k = 0..4), with the most significant byte at the lowest address. Word k belongs to store index base+k. For a filter section, the five words are b1, b2, a1, a2 and b0, in that order.
- R4: Writing bit 0 of the control register stores word 0 at the index held in the index register. The write happens at the next clock edge.
- R5: Control bit 1 writes words 0–4 to indices base..base+4. The transfer takes five clock edges after the strobe, and all five words change at the fifth edge together.
- R6: Control bit 2 loads the word at the base index into staging bytes 1–3 in one edge. Control bit 3 loads indices base..base+4 into staging bytes 1–15, one word per edge, over five edges.
- R7: When several strobe bits are set, only the lowest set bit runs.
- R8: The strobe bits clear at the edge where the transfer ends. Status bit 0 reads 1 while any strobe bit is set. No transfer lasts longer than five edges.
- R9: Control register bits 7:4 ignore writes and always read 0 (the reserved reset value). A write that sets only those bits starts no transfer.
- R10: While a transfer is running, host writes to any register are ignored.
- R11: Store writes to indices above 61 are dropped, and reads of those indices return 0. This includes the part of a five-word transfer that runs past index 61.
- R12: The datapath port returns the word at `dp_idx` one clock after that index is sampled, and returns 0 for indices above 61.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host register write enable |
| hst_rd | input | 1 | Host register read enable |
| hst_addr | input | 5 | Host register address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Registered host read data |
| dp_idx | input | 6 | Datapath coefficient index |
| dp_coef | output | 24 | Registered datapath coefficient |

## Verification
A store corrupted at reset, or written at the wrong index, shows on `dp_coef` one clock after the datapath asks for that index. It shows on the staging bytes after one read transfer. A stuck transfer engine keeps the status bit high and leaves the strobe bits set where the host can read them. A section written word by word instead of all at once would show a mixed section on the datapath port during the five busy edges. The bench models the expected value of both output ports on every clock, so any of these faults appears within a few cycles of the transfer that exposes it.

// File: rtl/coefram_pkg.sv
package coefram_pkg;
  localparam int unsigned COEF_W         = 24;
  localparam int unsigned BYTE_W         = 8;
  localparam int unsigned BYTES_PER_COEF = COEF_W / BYTE_W;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WR_ONE,
    OP_WR_SET,
    OP_RD_ONE,
    OP_RD_SET
  } xfer_op_e;

  // Power-on value of one store location
  function automatic logic [COEF_W-1:0] coef_reset_value(int unsigned idx);
    logic [COEF_W-1:0] v;
    v = '0;
    if (idx < 50) begin
      if ((idx % 5) == 4) v = 24'h400000;
    end else if (idx == 55) begin
      v = 24'h5A9DF7;
    end else if (idx <= 54 || idx == 56 || idx == 59) begin
      v = 24'h7FFFFF;
    end else if (idx == 60 || idx == 61) begin
      v = 24'h400000;
    end
    return v;
  endfunction
endpackage

// File: rtl/coef_store.sv
module coef_store
  import coefram_pkg::*;
#(
  parameter int unsigned NUM_COEF = 62,
  parameter int unsigned SET_LEN  = 5,
  parameter int unsigned IDX_W    = 9,
  parameter int unsigned DP_W     = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SET_LEN-1:0]        wr_mask,
  input  logic [IDX_W-1:0]          wr_base,
  input  logic [SET_LEN*COEF_W-1:0] wr_data,
  input  logic [IDX_W-1:0]          eng_idx,
  output logic [COEF_W-1:0]         eng_q,
  input  logic [DP_W-1:0]           dp_idx,
  output logic [COEF_W-1:0]         dp_q
);
  logic [COEF_W-1:0] mem_q [NUM_COEF];
  logic [COEF_W-1:0] dp_sel;

  // All lanes of a section land in the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NUM_COEF; e++) mem_q[e] <= coef_reset_value(e);
    end else if (wr_en) begin
      for (int e = 0; e < NUM_COEF; e++) begin
        for (int k = 0; k < SET_LEN; k++) begin
          if (wr_mask[k] && ((wr_base + IDX_W'(k)) == IDX_W'(e)))
            mem_q[e] <= wr_data[k*COEF_W +: COEF_W];
        end
      end
    end
  end

  // Out-of-range indices fall through to zero
  always_comb begin
    eng_q = '0;
    for (int e = 0; e < NUM_COEF; e++)
      if (eng_idx == IDX_W'(e)) eng_q = mem_q[e];
  end

  always_comb begin
    dp_sel = '0;
    for (int e = 0; e < NUM_COEF; e++)
      if (dp_idx == DP_W'(e)) dp_sel = mem_q[e];
  end

  always_ff @(posedge clk) begin
    if (rst) dp_q <= '0;
    else     dp_q <= dp_sel;
  end
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import coefram_pkg::*;
#(
  parameter int unsigned SET_LEN = 5,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         strobe,
  input  logic [BYTE_W-1:0]  base,
  output logic               busy,
  output logic               done,
  output logic               mem_wr,
  output logic [SET_LEN-1:0] mem_mask,
  output logic [IDX_W-1:0]   mem_base,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               stg_ld,
  output logic [CNT_W-1:0]   stg_slot
);
  xfer_op_e         op;
  logic [CNT_W-1:0] cnt_q;
  logic             last_step;

  // Lowest strobe bit wins
  always_comb begin
    if      (strobe[0]) op = OP_WR_ONE;
    else if (strobe[1]) op = OP_WR_SET;
    else if (strobe[2]) op = OP_RD_ONE;
    else if (strobe[3]) op = OP_RD_SET;
    else                op = OP_NONE;
  end

  assign busy      = (op != OP_NONE);
  assign last_step = (cnt_q == CNT_W'(SET_LEN - 1));
  assign done      = (op == OP_WR_ONE) || (op == OP_RD_ONE) ||
                     (((op == OP_WR_SET) || (op == OP_RD_SET)) && last_step);
  assign mem_wr    = done && ((op == OP_WR_ONE) || (op == OP_WR_SET));
  assign mem_mask  = (op == OP_WR_SET) ? '1 : SET_LEN'(1);
  assign mem_base  = IDX_W'(base);
  assign rd_idx    = IDX_W'(base) + IDX_W'(cnt_q);
  assign stg_ld    = (op == OP_RD_ONE) || (op == OP_RD_SET);
  assign stg_slot  = (op == OP_RD_SET) ? cnt_q : '0;

  always_ff @(posedge clk) begin
    if (rst || done || !busy) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/host_regs.sv
module host_regs
  import coefram_pkg::*;
#(
  parameter int unsigned SET_LEN  = 5,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CNT_W    = 3,
  parameter logic [3:0]  RSVD_RST = 4'h0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hst_wr,
  input  logic                      hst_rd,
  input  logic [ADDR_W-1:0]         hst_addr,
  input  logic [BYTE_W-1:0]         hst_wdata,
  output logic [BYTE_W-1:0]         hst_rdata,
  input  logic                      eng_done,
  input  logic                      stg_ld,
  input  logic [CNT_W-1:0]          stg_slot,
  input  logic [COEF_W-1:0]         stg_word,
  output logic [3:0]                strobe,
  output logic [BYTE_W-1:0]         base,
  output logic [SET_LEN*COEF_W-1:0] lanes
);
  localparam int unsigned STG_N = SET_LEN * BYTES_PER_COEF;
  localparam logic [ADDR_W-1:0] A_IDX  = '0;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(STG_N + 1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STG_N + 2);

  logic [BYTE_W-1:0] stg_q [STG_N];
  logic [3:0]        strobe_q;
  logic [BYTE_W-1:0] base_q;
  logic [BYTE_W-1:0] rd_val;
  logic              locked;

  assign locked = |strobe_q;
  assign strobe = strobe_q;
  assign base   = base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q  <= '0;
      base_q    <= '0;
      hst_rdata <= '0;
      for (int i = 0; i < STG_N; i++) stg_q[i] <= '0;
    end else begin
      hst_rdata <= hst_rd ? rd_val : '0;
      if (eng_done) strobe_q <= '0;
      if (stg_ld) begin
        for (int i = 0; i < STG_N; i++) begin
          if (CNT_W'(i / BYTES_PER_COEF) == stg_slot)
            stg_q[i] <= stg_word[(BYTES_PER_COEF-1-(i % BYTES_PER_COEF))*BYTE_W +: BYTE_W];
        end
      end
      if (hst_wr && !locked) begin
        if (hst_addr == A_IDX)  base_q   <= hst_wdata;
        if (hst_addr == A_CTRL) strobe_q <= hst_wdata[3:0];
        for (int i = 0; i < STG_N; i++)
          if (hst_addr == ADDR_W'(i + 1)) stg_q[i] <= hst_wdata;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (hst_addr == A_IDX)  rd_val = base_q;
    if (hst_addr == A_CTRL) rd_val = {RSVD_RST, strobe_q};
    if (hst_addr == A_STAT) rd_val = {7'b0, locked};
    for (int i = 0; i < STG_N; i++)
      if (hst_addr == ADDR_W'(i + 1)) rd_val = stg_q[i];
  end

  // Word k: most significant byte at the lowest staging address
  for (genvar k = 0; k < SET_LEN; k++) begin : g_lane
    for (genvar b = 0; b < BYTES_PER_COEF; b++) begin : g_byte
      assign lanes[k*COEF_W + (BYTES_PER_COEF-1-b)*BYTE_W +: BYTE_W] =
        stg_q[k*BYTES_PER_COEF + b];
    end
  end
endmodule

// File: rtl/coef_ram_ctrl.sv
module coef_ram_ctrl
  import coefram_pkg::*;
#(
  parameter int unsigned NUM_COEF = 62,
  parameter int unsigned SET_LEN  = 5,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DP_W     = 6,
  parameter logic [3:0]  RSVD_RST = 4'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [7:0]        hst_wdata,
  output logic [7:0]        hst_rdata,
  input  logic [DP_W-1:0]   dp_idx,
  output logic [23:0]       dp_coef
);
  localparam int unsigned IDX_W = BYTE_W + 1;
  localparam int unsigned CNT_W = (SET_LEN > 1) ? $clog2(SET_LEN) : 1;

  logic [3:0]                strobe_w;
  logic [BYTE_W-1:0]         base_w;
  logic [SET_LEN*COEF_W-1:0] lanes_w;
  logic                      busy_w, done_w, mem_wr_w, stg_ld_w;
  logic [SET_LEN-1:0]        mem_mask_w;
  logic [IDX_W-1:0]          mem_base_w, rd_idx_w;
  logic [CNT_W-1:0]          stg_slot_w;
  logic [COEF_W-1:0]         eng_q_w;

  host_regs #(
    .SET_LEN(SET_LEN), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RSVD_RST(RSVD_RST)
  ) i_regs (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .eng_done(done_w), .stg_ld(stg_ld_w), .stg_slot(stg_slot_w),
    .stg_word(eng_q_w), .strobe(strobe_w), .base(base_w), .lanes(lanes_w)
  );

  xfer_engine #(
    .SET_LEN(SET_LEN), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) i_eng (
    .clk(clk), .rst(rst), .strobe(strobe_w), .base(base_w),
    .busy(busy_w), .done(done_w), .mem_wr(mem_wr_w), .mem_mask(mem_mask_w),
    .mem_base(mem_base_w), .rd_idx(rd_idx_w), .stg_ld(stg_ld_w),
    .stg_slot(stg_slot_w)
  );

  coef_store #(
    .NUM_COEF(NUM_COEF), .SET_LEN(SET_LEN), .IDX_W(IDX_W), .DP_W(DP_W)
  ) i_store (
    .clk(clk), .rst(rst), .wr_en(mem_wr_w), .wr_mask(mem_mask_w),
    .wr_base(mem_base_w), .wr_data(lanes_w), .eng_idx(rd_idx_w),
    .eng_q(eng_q_w), .dp_idx(dp_idx), .dp_q(dp_coef)
  );
endmodule

// File: rtl/coef_ram_ctrl_chk.sv
module coef_ram_ctrl_chk #(
  parameter int unsigned NUM_COEF = 62,
  parameter int unsigned SET_LEN  = 5,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DP_W     = 6,
  parameter logic [3:0]  RSVD_RST = 4'h0
) (
  input logic               clk,
  input logic               rst,
  input logic               hst_rd,
  input logic [ADDR_W-1:0]  hst_addr,
  input logic [7:0]         hst_rdata,
  input logic [DP_W-1:0]    dp_idx,
  input logic [23:0]        dp_coef,
  input logic [3:0]         strobe,
  input logic [7:0]         base,
  input logic               mem_wr,
  input logic [SET_LEN-1:0] mem_mask,
  input logic               eng_done
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(SET_LEN * 3 + 1);

  int unsigned run_q;
  always_ff @(posedge clk) begin
    if (rst)          run_q <= 0;
    else if (|strobe) run_q <= run_q + 1;
    else              run_q <= 0;
  end

  a_r9_rsvd_read: assert property (@(posedge clk) disable iff (rst)
    $past(hst_rd && (hst_addr == A_CTRL)) |-> (hst_rdata[7:4] == RSVD_RST));

  a_r12_dp_range: assert property (@(posedge clk) disable iff (rst)
    (int'($past(dp_idx)) >= NUM_COEF) |-> (dp_coef == '0));

  a_r10_base_locked: assert property (@(posedge clk) disable iff (rst)
    $past(|strobe) |-> $stable(base));

  a_r4_write_at_end: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (eng_done && (|strobe)));

  a_r5_whole_section: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (($countones(mem_mask) == 1) || (mem_mask == '1)));

  a_r8_self_clear: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> (strobe == '0));

  a_r8_bounded_run: assert property (@(posedge clk) disable iff (rst)
    run_q <= SET_LEN);
endmodule

bind coef_ram_ctrl coef_ram_ctrl_chk #(
  .NUM_COEF(NUM_COEF), .SET_LEN(SET_LEN), .ADDR_W(ADDR_W),
  .DP_W(DP_W), .RSVD_RST(RSVD_RST)
) i_chk (
  .clk(clk), .rst(rst), .hst_rd(hst_rd), .hst_addr(hst_addr),
  .hst_rdata(hst_rdata), .dp_idx(dp_idx), .dp_coef(dp_coef),
  .strobe(strobe_w), .base(base_w), .mem_wr(mem_wr_w),
  .mem_mask(mem_mask_w), .eng_done(done_w)
);

// File: tb/test_coef_ram_ctrl.sv
module test_coef_ram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 62;
  localparam int L      = 5;
  localparam int STG_N  = 15;
  localparam logic [4:0] A_IDX  = 5'd0;
  localparam logic [4:0] A_CTRL = 5'd16;
  localparam logic [4:0] A_STAT = 5'd17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_wr = 1'b0, hst_rd = 1'b0;
  logic [4:0]  hst_addr = '0;
  logic [7:0]  hst_wdata = '0;
  logic [7:0]  hst_rdata;
  logic [5:0]  dp_idx = '0;
  logic [23:0] dp_coef;

  int    n_run = 0, n_fail = 0;
  string cur_req = "R1";

  // behavioural model state
  logic [23:0] m_mem [64];
  logic [7:0]  m_stg [STG_N];
  logic [7:0]  m_base;
  logic [3:0]  m_str;
  int          m_cnt;
  logic [7:0]  m_rdata;
  logic [23:0] m_dp;

  always #(CLK_PERIOD/2) clk = ~clk;

  coef_ram_ctrl i_coef_ram_ctrl (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .dp_idx(dp_idx), .dp_coef(dp_coef)
  );

  function automatic logic [23:0] exp_reset(int i);
    if (i >= N) return 24'h0;
    if (i < 50) return ((i % 5) == 4) ? 24'h400000 : 24'h0;
    if (i == 55) return 24'h5A9DF7;
    if (i <= 54 || i == 56 || i == 59) return 24'h7FFFFF;
    if (i >= 60) return 24'h400000;
    return 24'h0;
  endfunction

  function automatic logic [7:0] stage_val(int i);
    return 8'(i * 17 + 3);
  endfunction

  function automatic logic [23:0] lane_val(int k);
    return {stage_val(3*k), stage_val(3*k+1), stage_val(3*k+2)};
  endfunction

  function automatic logic [23:0] mem_at(int i);
    return (i < N) ? m_mem[i] : 24'h0;
  endfunction

  function automatic logic [7:0] m_read(logic [4:0] a);
    if (a == A_IDX)  return m_base;
    if (a == A_CTRL) return {4'h0, m_str};
    if (a == A_STAT) return {7'b0, (m_str != 0)};
    if (a >= 5'd1 && a <= 5'd15) return m_stg[int'(a) - 1];
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_mem[i] = exp_reset(i);
    for (int i = 0; i < STG_N; i++) m_stg[i] = 8'h00;
    m_base = '0; m_str = '0; m_cnt = 0; m_rdata = '0; m_dp = '0;
  endtask

  task automatic put_word(int slot, logic [23:0] w);
    m_stg[3*slot]   = w[23:16];
    m_stg[3*slot+1] = w[15:8];
    m_stg[3*slot+2] = w[7:0];
  endtask

  function automatic logic [23:0] stg_word(int k);
    return {m_stg[3*k], m_stg[3*k+1], m_stg[3*k+2]};
  endfunction

  task automatic model_step();
    bit busy, done;
    int b0;
    busy = (m_str != 0);
    done = 0;
    m_rdata = hst_rd ? m_read(hst_addr) : 8'h00;
    m_dp = (int'(dp_idx) < N) ? m_mem[int'(dp_idx)] : 24'h0;
    if (busy) begin
      b0 = int'(m_base);
      if (m_str[0]) begin
        if (b0 < N) m_mem[b0] = stg_word(0);
        done = 1;
      end else if (m_str[1]) begin
        if (m_cnt == L-1) begin
          for (int k = 0; k < L; k++) if (b0 + k < N) m_mem[b0+k] = stg_word(k);
          done = 1;
        end
      end else if (m_str[2]) begin
        put_word(0, mem_at(b0));
        done = 1;
      end else begin
        put_word(m_cnt, mem_at(b0 + m_cnt));
        if (m_cnt == L-1) done = 1;
      end
      if (done) begin m_str = '0; m_cnt = 0; end
      else m_cnt++;
    end else if (hst_wr) begin
      if (hst_addr == A_IDX) m_base = hst_wdata;
      else if (hst_addr == A_CTRL) m_str = hst_wdata[3:0];
      else if (hst_addr >= 5'd1 && hst_addr <= 5'd15) m_stg[int'(hst_addr)-1] = hst_wdata;
    end
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    chk({cur_req, " rdata"}, 32'(hst_rdata), 32'(m_rdata));
    chk({cur_req, " dp"}, 32'(dp_coef), 32'(m_dp));
    @(negedge clk);
  endtask

  task automatic hwr(logic [4:0] a, logic [7:0] d);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    tick();
    hst_wr = 1'b0;
  endtask

  task automatic hrd(logic [4:0] a, output logic [7:0] v);
    hst_rd = 1'b1; hst_addr = a;
    tick();
    v = hst_rdata;
    hst_rd = 1'b0;
  endtask

  task automatic dp_get(int i, output logic [23:0] v);
    dp_idx = 6'(i);
    tick();
    v = dp_coef;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int t = 0; t < 20; t++) begin
      hrd(A_STAT, s);
      if (m_str == 0 && s == 8'h00) break;
    end
  endtask

  task automatic stage_all();
    for (int i = 0; i < STG_N; i++) hwr(5'(i + 1), stage_val(i));
  endtask

  initial begin
    logic [7:0]  r;
    logic [23:0] w;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset contents over the full index range
    cur_req = "R1";
    for (int i = 0; i < 64; i++) begin
      dp_get(i, w);
      chk("R1", 32'(w), 32'(exp_reset(i)));
    end
    hrd(A_CTRL, r); chk("R1", 32'(r), 32'h00);
    hrd(A_STAT, r); chk("R1", 32'(r), 32'h00);

    // R2: map, unmapped address, idle read data
    cur_req = "R2";
    hwr(A_IDX, 8'h2A);
    hrd(A_IDX, r); chk("R2", 32'(r), 32'h2A);
    hrd(5'd20, r); chk("R2", 32'(r), 32'h00);
    tick(); chk("R2", 32'(hst_rdata), 32'h00);

    // R3 / R4 / R8: single word write
    cur_req = "R4";
    hwr(5'd1, 8'h12); hwr(5'd2, 8'h34); hwr(5'd3, 8'h56);
    hwr(A_IDX, 8'd50);
    hwr(A_CTRL, 8'h01);
    hrd(A_STAT, r); chk("R8", 32'(r), 32'h01);
    hrd(A_CTRL, r); chk("R8", 32'(r), 32'h00);
    dp_get(50, w); chk("R3", 32'(w), 32'h123456);
    dp_get(51, w); chk("R4", 32'(w), 32'h7FFFFF);

    // R5 / R10 / R12: atomic section write at index 5
    cur_req = "R5";
    stage_all();
    hwr(A_IDX, 8'd5);
    dp_idx = 6'd9;
    hwr(A_CTRL, 8'h02);
    for (int t = 0; t < L; t++) begin
      if (t == 1) hwr(A_IDX, 8'h20);
      else if (t == 2) hwr(5'd1, 8'hEE);
      else tick();
      chk("R5", 32'(dp_coef), 32'h400000);
    end
    tick();
    chk("R12", 32'(dp_coef), 32'(lane_val(4)));
    cur_req = "R10";
    hrd(A_IDX, r); chk("R10", 32'(r), 32'd5);
    hrd(5'd1, r);  chk("R10", 32'(r), 32'(stage_val(0)));
    cur_req = "R5";
    for (int k = 0; k < L; k++) begin
      dp_get(5 + k, w); chk("R5", 32'(w), 32'(lane_val(k)));
    end

    // R6: section read and single read into staging
    cur_req = "R6";
    for (int i = 0; i < STG_N; i++) hwr(5'(i + 1), 8'h00);
    hwr(A_CTRL, 8'h08);
    wait_idle();
    for (int i = 0; i < STG_N; i++) begin
      hrd(5'(i + 1), r); chk("R6", 32'(r), 32'(stage_val(i)));
    end
    hwr(A_IDX, 8'd50);
    hwr(A_CTRL, 8'h04);
    wait_idle();
    hrd(5'd1, r); chk("R6", 32'(r), 32'h12);
    hrd(5'd3, r); chk("R6", 32'(r), 32'h56);
    hrd(5'd4, r); chk("R6", 32'(r), 32'(stage_val(3)));

    // R7: lowest strobe bit wins
    cur_req = "R7";
    hwr(5'd1, 8'hAB); hwr(5'd2, 8'hCD); hwr(5'd3, 8'hEF);
    hwr(A_IDX, 8'd51);
    hwr(A_CTRL, 8'h0F);
    tick();
    hrd(A_STAT, r); chk("R7", 32'(r), 32'h00);
    dp_get(51, w);  chk("R7", 32'(w), 32'hABCDEF);
    dp_get(52, w);  chk("R7", 32'(w), 32'h7FFFFF);

    // R9: reserved control bits
    cur_req = "R9";
    hwr(A_CTRL, 8'hF0);
    hrd(A_STAT, r); chk("R9", 32'(r), 32'h00);
    hrd(A_CTRL, r); chk("R9", 32'(r), 32'h00);

    // R11: writes and reads past the end of the store
    cur_req = "R11";
    hwr(5'd1, 8'h11); hwr(5'd2, 8'h11); hwr(5'd3, 8'h11);
    hwr(A_IDX, 8'd62);
    hwr(A_CTRL, 8'h01);
    wait_idle();
    dp_get(61, w); chk("R11", 32'(w), 32'h400000);
    dp_get(62, w); chk("R11", 32'(w), 32'h0);
    stage_all();
    hwr(A_IDX, 8'd59);
    hwr(A_CTRL, 8'h02);
    wait_idle();
    dp_get(59, w); chk("R11", 32'(w), 32'(lane_val(0)));
    dp_get(61, w); chk("R11", 32'(w), 32'(lane_val(2)));
    dp_get(63, w); chk("R12", 32'(w), 32'h0);
    dp_get(58, w); chk("R11", 32'(w), 32'h0);
    hwr(A_CTRL, 8'h08);
    wait_idle();
    hrd(5'd7, r);  chk("R11", 32'(r), 32'(stage_val(6)));
    hrd(5'd10, r); chk("R11", 32'(r), 32'h00);
    hrd(5'd15, r); chk("R11", 32'(r), 32'h00);
    hwr(A_IDX, 8'd200);
    hwr(A_CTRL, 8'h04);
    wait_idle();
    hrd(5'd1, r); chk("R11", 32'(r), 32'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule